// File: doc/BRIEF.md
# Stepper Axis Motion Profile Generator

This block drives one stepper motor axis from a small register set. Software writes a signed 32-bit count of steps still to take, either by loading it outright or by adding a signed amount to it. The block then emits step pulses and a direction level until the count reaches zero. Each step moves the count one unit toward zero. Speed follows a trapezoidal profile. Motion starts at a minimum velocity and rises by the acceleration setting toward a maximum velocity. It then slows back to the minimum at the same rate, so that it arrives at zero with the speed low.

Time is measured in ticks of a fixed timebase. A tick occurs once every `CLK_PER_TICK` clocks, and `TICK_HZ` gives the number of ticks per second. Velocities are in steps per second and acceleration in steps per second squared. At most one step is emitted per tick. When the count goes from nonzero to zero, the block raises a report request that carries the status word. Motion may be cut short at once by an emergency-stop pin or by a control write.

Register writes arrive on a valid/ready channel. `wr_ready` is low only on tick cycles, when the count may move by a step. A write takes effect on a clock where both `wr_valid` and `wr_ready` are high. The master must hold `wr_addr` and `wr_data` stable while `wr_valid` is high and `wr_ready` is low. The report channel is also valid/ready. Once `rpt_valid` rises, it and `rpt_status` stay unchanged until a clock where `rpt_ready` is high. Reads are combinational from `rd_addr`.

Top module: `stepper_axis_gen`

## Requirements
- R1: After reset the count, the status word, the three speed settings, `step_out`, `dir_out` and `rpt_valid` are all zero.
- R2: A write to offset 2 loads the count with the written value. Reads at offset 2 or 3 return the count.
- R3: A write to offset 3 adds the signed value to the count. On signed overflow the count saturates to 0x7FFFFFFF or 0x80000000 and status bit 1 is set. Status bit 1 stays set until a control write (offset 1) with bit 1 high.
- R4: While the count is nonzero, step pulses are emitted and each one moves the count one toward zero. The number of pulses equals the magnitude of the loaded count.
- R5: Status bit 0 is high while the count is nonzero. `dir_out` and status bit 2 are 1 for a negative count and 0 for a positive one, and hold their value once the count is zero.
- R6: With equal minimum and maximum velocity v, steps are spaced TICK_HZ/v ticks apart. A velocity above TICK_HZ is treated as TICK_HZ, which gives one step per tick.
- R7: The first steps are spaced wider than the cruise spacing. Cruise runs at the maximum velocity. Deceleration begins once the remaining magnitude is no more than the steps taken while accelerating, and the last steps are again wider than the cruise spacing.
- R8: A high `estop` input, or a control write with bit 0 high, clears the count to zero on the next clock. No further step pulse begins after that.
- R9: `rpt_valid` rises on the same clock that the count becomes zero from nonzero, stays high while `rpt_ready` is low, and falls after a clock with `rpt_ready` high.
- R10: `wr_ready` is low on tick cycles only. Writes to offset 0 or offset 4 change nothing. Offsets 5, 6 and 7 hold the minimum velocity, maximum velocity and acceleration.
- R11: Each step pulse stays high for `PULSE_CLKS` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted this clock (low on tick cycles) |
| wr_addr | input | 3 | Register offset for the write |
| wr_data | input | 32 | Write value |
| rd_addr | input | 3 | Register offset for the read |
| rd_data | output | 32 | Combinational read value |
| estop | input | 1 | Emergency stop, level sensitive |
| step_out | output | 1 | Step pulse |
| dir_out | output | 1 | Direction, 1 = negative count |
| rpt_valid | output | 1 | Report request pending |
| rpt_ready | input | 1 | Report accepted |
| rpt_status | output | 32 | Status word carried with the report |

## Verification
The hardest case to reach from the ports is saturation on an add. The count must sit a few units below an int32 limit without the motion engine consuming it. The same count must also be read back before any step lands. The stimulus therefore first sets the minimum and maximum velocity to one step per second, so a step is hundreds of clocks away. It then loads a value near the limit, adds past it, and reads the count and the sticky flag at once. A stalled report handshake is reached by holding `rpt_ready` low across the end of a short, fast move.

// File: rtl/stepper_axis_pkg.sv
package stepper_axis_pkg;
  typedef enum logic [2:0] {
    OFS_STATUS = 3'd0,
    OFS_CTRL   = 3'd1,
    OFS_LOAD   = 3'd2,
    OFS_ADJ    = 3'd3,
    OFS_SPARE  = 3'd4,
    OFS_VLOW   = 3'd5,
    OFS_VHIGH  = 3'd6,
    OFS_RATE   = 3'd7
  } axis_ofs_e;

  localparam int STS_BUSY = 0;
  localparam int STS_OVF  = 1;
  localparam int STS_NEG  = 2;
  localparam int CTL_HALT = 0;
  localparam int CTL_CLRO = 1;
endpackage

// File: rtl/axis_timebase.sv
module axis_timebase #(
  parameter int CLK_PER_TICK = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else begin
      div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
      tick  <= (div_q == LAST);
    end
  end

  generate
    if (CLK_PER_TICK > 1) begin : g_spacing
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R10
    end
  endgenerate
endmodule

// File: rtl/axis_ramp.sv
module axis_ramp #(
  parameter int TICK_HZ = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        run,
  input  logic [31:0] rem_mag,
  input  logic [31:0] vlow,
  input  logic [31:0] vhigh,
  input  logic [31:0] rate,
  output logic        step_evt
);
  localparam logic [63:0] T64  = 64'(TICK_HZ);
  localparam logic [63:0] FULL = T64 * T64;
  localparam logic [31:0] T32  = 32'(TICK_HZ);

  logic [31:0] vhigh_c, vlow_c, ramp_q;
  logic [63:0] vhigh_s, vlow_s, rate_s;
  logic [63:0] vel_q, phase_q, ph_sum;
  logic        slowing;

  always_comb begin
    vhigh_c = (vhigh > T32) ? T32 : vhigh;
    vlow_c  = (vlow > vhigh_c) ? vhigh_c : vlow;
    vhigh_s = {32'b0, vhigh_c} * T64;
    vlow_s  = {32'b0, vlow_c} * T64;
    rate_s  = {32'b0, rate};
    ph_sum  = phase_q + vel_q;
    slowing = (rem_mag <= ramp_q);
    step_evt = tick && run && (ph_sum >= FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vel_q   <= '0;
      phase_q <= '0;
      ramp_q  <= '0;
    end else if (!run) begin
      vel_q   <= vlow_s;
      phase_q <= '0;
      ramp_q  <= '0;
    end else if (tick) begin
      phase_q <= step_evt ? ph_sum - FULL : ph_sum;
      if (slowing)
        vel_q <= (vel_q > vlow_s + rate_s) ? vel_q - rate_s : vlow_s;
      else
        vel_q <= (vel_q + rate_s < vhigh_s) ? vel_q + rate_s : vhigh_s;
      if (step_evt) begin
        if (slowing)
          ramp_q <= (ramp_q != 0) ? ramp_q - 1'b1 : '0;
        else if (vel_q < vhigh_s)
          ramp_q <= ramp_q + 1'b1;
      end
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < FULL); // R6
  AST_VEL_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    vel_q <= FULL); // R6
endmodule

// File: rtl/axis_pulse.sv
module axis_pulse #(
  parameter int PULSE_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int PW = $clog2(PULSE_CLKS + 1);
  localparam logic [PW-1:0] LOADV = PW'(PULSE_CLKS);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        left_q <= '0;
    else if (fire)     left_q <= LOADV;
    else if (left_q != 0) left_q <= left_q - 1'b1;
  end

  assign pulse = (left_q != 0);

  generate
    if (PULSE_CLKS > 1) begin : g_width
      AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |=> pulse); // R11
    end
  endgenerate
endmodule

// File: rtl/axis_regs.sv
module axis_regs
  import stepper_axis_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_fire,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        estop,
  input  logic        step_evt,
  input  logic        rpt_ready,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic [31:0] count_q,
  output logic [31:0] rem_mag,
  output logic        busy,
  output logic        neg_q,
  output logic [31:0] vlow_q,
  output logic [31:0] vhigh_q,
  output logic [31:0] rate_q,
  output logic        rpt_valid,
  output logic [31:0] status
);
  logic [32:0] sum33;
  logic        add_ovf, halt_any, ovf_q, ovf_d;
  logic [31:0] cnt_d;
  axis_ofs_e   wsel;

  assign wsel    = axis_ofs_e'(wr_addr);
  assign sum33   = {count_q[31], count_q} + {wr_data[31], wr_data};
  assign add_ovf = sum33[32] != sum33[31];
  assign halt_any = estop || (wr_fire && wsel == OFS_CTRL && wr_data[CTL_HALT]);
  assign busy    = (count_q != 0);
  assign rem_mag = count_q[31] ? (~count_q + 1'b1) : count_q;

  always_comb begin
    status = '0;
    status[STS_BUSY] = busy;
    status[STS_OVF]  = ovf_q;
    status[STS_NEG]  = neg_q;
  end

  always_comb begin
    cnt_d = count_q;
    ovf_d = ovf_q;
    if (step_evt) cnt_d = count_q[31] ? count_q + 1'b1 : count_q - 1'b1;
    if (wr_fire) begin
      case (wsel)
        OFS_LOAD: cnt_d = wr_data;
        OFS_ADJ: begin
          if (add_ovf) begin
            cnt_d = sum33[32] ? 32'h8000_0000 : 32'h7FFF_FFFF;
            ovf_d = 1'b1;
          end else begin
            cnt_d = sum33[31:0];
          end
        end
        OFS_CTRL: if (wr_data[CTL_CLRO]) ovf_d = 1'b0;
        default: ;
      endcase
    end
    if (halt_any) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      ovf_q     <= 1'b0;
      neg_q     <= 1'b0;
      vlow_q    <= '0;
      vhigh_q   <= '0;
      rate_q    <= '0;
      rpt_valid <= 1'b0;
    end else begin
      count_q <= cnt_d;
      ovf_q   <= ovf_d;
      if (cnt_d != 0) neg_q <= cnt_d[31];
      if (wr_fire && wsel == OFS_VLOW)  vlow_q  <= wr_data;
      if (wr_fire && wsel == OFS_VHIGH) vhigh_q <= wr_data;
      if (wr_fire && wsel == OFS_RATE)  rate_q  <= wr_data;
      if (count_q != 0 && cnt_d == 0) rpt_valid <= 1'b1;
      else if (rpt_ready)             rpt_valid <= 1'b0;
    end
  end

  always_comb begin
    case (axis_ofs_e'(rd_addr))
      OFS_STATUS: rd_data = status;
      OFS_LOAD,
      OFS_ADJ:    rd_data = count_q;
      OFS_VLOW:   rd_data = vlow_q;
      OFS_VHIGH:  rd_data = vhigh_q;
      OFS_RATE:   rd_data = rate_q;
      default:    rd_data = '0;
    endcase
  end

  AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    estop |=> count_q == 0); // R8
  AST_STEP_TOWARD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !wr_fire && !estop) |=>
      (count_q == ($past(count_q[31]) ? $past(count_q) + 32'd1 : $past(count_q) - 32'd1))); // R4
  AST_REPORT_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rpt_valid); // R9
  AST_REPORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_ready) |=> rpt_valid); // R9
  AST_ADD_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wsel == OFS_ADJ && add_ovf && !estop) |=>
      (ovf_q && (count_q == 32'h7FFF_FFFF || count_q == 32'h8000_0000))); // R3
endmodule

// File: rtl/stepper_axis_gen.sv
module stepper_axis_gen #(
  parameter int TICK_HZ      = 1000,
  parameter int CLK_PER_TICK = 100000,
  parameter int PULSE_CLKS   = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        estop,
  output logic        step_out,
  output logic        dir_out,
  output logic        rpt_valid,
  input  logic        rpt_ready,
  output logic [31:0] rpt_status
);
  logic        tick, step_evt, busy, neg_q, wr_fire;
  logic [31:0] count_q, rem_mag, vlow_q, vhigh_q, rate_q, status;

  assign wr_ready = !tick;
  assign wr_fire  = wr_valid && wr_ready;
  assign dir_out  = neg_q;
  assign rpt_status = status;

  axis_timebase #(.CLK_PER_TICK(CLK_PER_TICK)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  axis_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_data(wr_data), .estop(estop), .step_evt(step_evt),
    .rpt_ready(rpt_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .count_q(count_q), .rem_mag(rem_mag), .busy(busy), .neg_q(neg_q),
    .vlow_q(vlow_q), .vhigh_q(vhigh_q), .rate_q(rate_q),
    .rpt_valid(rpt_valid), .status(status));

  axis_ramp #(.TICK_HZ(TICK_HZ)) u_ramp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(busy && !estop),
    .rem_mag(rem_mag), .vlow(vlow_q), .vhigh(vhigh_q), .rate(rate_q),
    .step_evt(step_evt));

  axis_pulse #(.PULSE_CLKS(PULSE_CLKS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(step_evt), .pulse(step_out));

  AST_WRITE_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !tick); // R10
  AST_STEP_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |-> count_q != 0); // R4
endmodule

// File: tb/stepper_axis_gen_test.sv
`timescale 1ns/1ps
module stepper_axis_gen_test;
  localparam int TICK_HZ = 100;
  localparam int CPT     = 4;
  localparam int PW      = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_ready;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data, rpt_status;
  logic estop = 1'b0, step_out, dir_out, rpt_valid, rpt_ready = 1'b1;

  int checks = 0, fails = 0, cyc = 0, n_rise = 0, hi_len = 0, last_hi = 0;
  int rise_t[64];
  logic prev_step = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  stepper_axis_gen #(.TICK_HZ(TICK_HZ), .CLK_PER_TICK(CPT), .PULSE_CLKS(PW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .estop(estop), .step_out(step_out), .dir_out(dir_out),
    .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_status(rpt_status));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (step_out && !prev_step) begin
      if (n_rise < 64) rise_t[n_rise] = cyc;
      n_rise = n_rise + 1;
    end
    if (step_out) hi_len = hi_len + 1;
    else if (prev_step) begin last_hi = hi_len; hi_len = 0; end
    prev_step = step_out;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic speeds(input int lo, input int hi, input int acc);
    wr(3'd5, 32'(lo)); wr(3'd6, 32'(hi)); wr(3'd7, 32'(acc));
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk); rd(3'd0, s);
      if (!s[0]) break;
    end
    repeat (PW + 2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); check("R1 status", v, 0);
    rd(3'd2, v); check("R1 count", v, 0);
    rd(3'd5, v); check("R1 vmin", v, 0);
    rd(3'd6, v); check("R1 vmax", v, 0);
    rd(3'd7, v); check("R1 accel", v, 0);
    check("R1 step/dir/rpt", {29'b0, step_out, dir_out, rpt_valid}, 0);
  endtask

  task automatic t_const();
    logic [31:0] v;
    speeds(50, 50, 0);
    rd(3'd6, v); check("R10 vmax readback", v, 50);
    n_rise = 0;
    wr(3'd2, 32'd4);
    rd(3'd3, v); check("R2 load readback", v, 4);
    wait_idle();
    check("R4 pulse count", 32'(n_rise), 4);
    check("R6 spacing two ticks", 32'(rise_t[2] - rise_t[1]), 2 * CPT);
    check("R11 pulse width", 32'(last_hi), PW);
    check("R5 dir positive", {31'b0, dir_out}, 0);
    rd(3'd2, v); check("R4 count ends zero", v, 0);
  endtask

  task automatic t_clamp_neg();
    logic [31:0] v;
    speeds(500, 500, 0);
    n_rise = 0;
    wr(3'd2, 32'hFFFF_FFFD);
    rd(3'd0, v); check("R5 busy and negative", v & 32'h5, 32'h5);
    check("R5 dir pin negative", {31'b0, dir_out}, 1);
    wait_idle();
    check("R4 pulses for -3", 32'(n_rise), 3);
    check("R6 clamp one per tick", 32'(rise_t[2] - rise_t[1]), CPT);
    rd(3'd0, v); check("R5 dir held at zero", v, 32'h4);
  endtask

  task automatic t_trapezoid();
    int mn, g;
    speeds(10, 100, 500);
    n_rise = 0;
    wr(3'd2, 32'd30);
    wait_idle();
    check("R7 pulse count", 32'(n_rise), 30);
    mn = 1000000;
    for (int i = 1; i < 30; i++) begin
      g = rise_t[i] - rise_t[i-1];
      if (g < mn) mn = g;
    end
    check("R7 cruise at max", 32'(mn), CPT);
    check("R7 start slower", {31'b0, (rise_t[1] - rise_t[0]) > CPT}, 1);
    check("R7 end slower", {31'b0, (rise_t[29] - rise_t[28]) > CPT}, 1);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    speeds(1, 1, 0);
    wr(3'd2, 32'h7FFF_FFF0);
    wr(3'd3, 32'h0000_0100);
    rd(3'd2, v); check("R3 positive saturate", v, 32'h7FFF_FFFF);
    rd(3'd0, v); check("R3 ovf flag set", v & 32'h2, 32'h2);
    wr(3'd1, 32'h2);
    rd(3'd0, v); check("R3 ovf cleared", v & 32'h2, 0);
    rd(3'd2, v); check("R3 clear keeps count", v, 32'h7FFF_FFFF);
    wr(3'd2, 32'h8000_0010);
    wr(3'd3, 32'hFFFF_FF00);
    rd(3'd2, v); check("R3 negative saturate", v, 32'h8000_0000);
    wr(3'd2, 32'd10);
    wr(3'd3, 32'hFFFF_FFFD);
    rd(3'd2, v); check("R3 plain add", v, 7);
    rd(3'd0, v); check("R3 ovf sticky", v & 32'h2, 32'h2);
    wr(3'd1, 32'h1);
    rd(3'd2, v); check("R8 control halt", v, 0);
    wr(3'd1, 32'h2);
  endtask

  task automatic t_estop();
    logic [31:0] v;
    int snap;
    speeds(50, 50, 0);
    wr(3'd2, 32'd100);
    repeat (40) @(negedge clk);
    estop = 1'b1;
    @(negedge clk);
    rd(3'd2, v); check("R8 estop clears", v, 0);
    repeat (3) @(negedge clk);
    snap = n_rise;
    repeat (100) @(negedge clk);
    check("R8 no steps after stop", 32'(n_rise), 32'(snap));
    estop = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_report();
    logic [31:0] v;
    speeds(500, 500, 0);
    @(negedge clk);
    check("R9 idle before", {31'b0, rpt_valid}, 0);
    rpt_ready = 1'b0;
    wr(3'd2, 32'd2);
    wait_idle();
    check("R9 raised at zero", {31'b0, rpt_valid}, 1);
    repeat (20) @(negedge clk);
    check("R9 held while stalled", {31'b0, rpt_valid}, 1);
    check("R9 payload not busy", rpt_status & 32'h1, 0);
    rpt_ready = 1'b1;
    @(negedge clk);
    check("R9 cleared after accept", {31'b0, rpt_valid}, 0);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    int lows;
    speeds(1, 1, 0);
    wr(3'd2, 32'd5);
    wr(3'd4, 32'd99);
    rd(3'd2, v); check("R10 offset 4 ignored", v, 5);
    wr(3'd0, 32'h0000_0123);
    rd(3'd2, v); check("R10 offset 0 ignored", v, 5);
    rd(3'd0, v); check("R10 status unchanged", v, 32'h1);
    lows = 0;
    for (int i = 0; i < 4 * CPT; i++) begin
      @(negedge clk);
      if (!wr_ready) lows++;
    end
    check("R10 ready low once per tick", 32'(lows), 4);
    wr(3'd1, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_const();
    t_clamp_neg();
    t_trapezoid();
    t_overflow();
    t_estop();
    t_report();
    t_ignored();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule